// File: doc/BRIEF.md
# Serial Display Driver Register Core

This block is the digital heart of a driver for a multiplexed vacuum fluorescent display with three grid lines and twenty-nine anode lines. A microcontroller supplies a serial data line, a shift clock and a strobe. The block collects 32 serial bits in a shift register. A strobe-controlled transparent latch passes them on, and a table fixed at build time routes each latched bit to one grid or anode output. A separate enable input gates the three grid outputs only. The anode outputs are never gated.

The serial inputs are slow compared to the system clock. They are oversampled through synchronizer chains, and edge pulses are derived from the synchronized shift clock. The whole block therefore runs in one clock domain and contains no real latch. The last shift stage leaves the block on a cascade output. That output changes only on falling shift-clock edges, so a second device chained behind this one captures stable data on its own rising edge.

Top module: `vfd_serial_core`

## Requirements
- R1: Each rising edge of the serial shift clock moves every shift stage one place toward position 1 and captures the data line into position 32. After 32 edges the first bit sent sits in position 1 and bit k of the word sent lsb-first sits in position k+1.
- R2: The cascade output carries the position-1 stage. It changes only on falling edges of the serial shift clock, so after a rising edge it still shows the previous value until the next falling edge.
- R3: While the strobe is high the latch is transparent. The outputs follow the shift register, including any shifting that happens during that time.
- R4: While the strobe is low the latch holds its contents. Shifting in new bits does not change any grid or anode output.
- R5: With the grid enable low, all three grid outputs are low whatever their latched bits are. With it high, each grid output equals its latched bit.
- R6: The anode outputs ignore the grid enable and always equal their latched bits. A latched 1 drives an output high (on) and a latched 0 drives it low (off).
- R7: With the default table, position 1 drives grid 1, positions 2 and 3 drive grids 2 and 3, and positions 4 to 32 drive anodes 1 to 29.
- R8: The parameter OUT_POS assigns one shift position (0-based, 0 = position 1) to each output, listed as grids 1 to 3 and then anodes 1 to 29. Elaboration reports a table with an out-of-range or repeated position.
- R9: Reset clears every shift stage, every latch bit and the cascade output, so all grid, anode and cascade outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data, captured on rising shift-clock edges |
| strobe_i | input | 1 | Latch transparent while high, holding while low |
| grid_en_i | input | 1 | Grid output enable |
| grid_o | output | 3 | Grid drive, grid 1 in bit 0 |
| anode_o | output | 29 | Anode drive, anode 1 in bit 0 |
| cascade_o | output | 1 | Position-1 stage, retimed to falling shift-clock edges |

## Verification
The bench builds two copies of the block side by side from the same stimulus. One uses the default identity table. The other uses a reversed table, where output k takes position 32-k. The reversed copy shows that routing follows the parameter and not a fixed wiring. Both copies use two synchronizer stages. Every loaded word is therefore checked through two unrelated mappings, which exposes errors in bit order and in the grid/anode split.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    localparam int unsigned VFD_GRIDS     = 3;
    localparam int unsigned VFD_ANODES    = 29;
    localparam int unsigned VFD_OUTS      = VFD_GRIDS + VFD_ANODES;
    localparam int unsigned VFD_SHIFT_LEN = 32;

    // entry k: 0-based shift position feeding output k (grids first, then anodes)
    typedef int unsigned pos_tbl_t [VFD_OUTS];

    localparam pos_tbl_t VFD_IDENT_POS = '{
        0,  1,  2,  3,  4,  5,  6,  7,
        8,  9,  10, 11, 12, 13, 14, 15,
        16, 17, 18, 19, 20, 21, 22, 23,
        24, 25, 26, 27, 28, 29, 30, 31
    };

endpackage

// File: rtl/vfd_edge_sync.sv
module vfd_edge_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [W-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.pipe[STAGES-1];
    assign rise_o  = level_o & ~st_q.prev;
    assign fall_o  = ~level_o & st_q.prev;

endmodule

// File: rtl/vfd_shift_latch.sv
module vfd_shift_latch #(
    parameter int unsigned SHIFT_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_i,
    input  logic                 fall_i,
    input  logic                 dat_i,
    input  logic                 stb_i,
    output logic [SHIFT_LEN-1:0] lat_o,
    output logic                 casc_o
);

    typedef struct packed {
        logic [SHIFT_LEN-1:0] sr;
        logic [SHIFT_LEN-1:0] lat;
        logic                 casc;
    } sl_st_t;

    sl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) st_d.sr   = {dat_i, st_q.sr[SHIFT_LEN-1:1]};
        if (fall_i)  st_d.casc = st_q.sr[0];
        if (stb_i)   st_d.lat  = st_d.sr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_o  = st_q.lat;
    assign casc_o = st_q.casc;

    // R1
    sr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (st_q.sr[SHIFT_LEN-2:0] == $past(st_q.sr[SHIFT_LEN-1:1])));

    // R1
    sr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(st_q.sr));

    // R2
    casc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(casc_o));

    // R3
    lat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> (lat_o == st_q.sr));

    // R4
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(lat_o));

endmodule

// File: rtl/vfd_out_map.sv
module vfd_out_map
    import vfd_pkg::*;
#(
    parameter int unsigned SHIFT_LEN = VFD_SHIFT_LEN,
    parameter pos_tbl_t    OUT_POS   = VFD_IDENT_POS
) (
    input  logic [SHIFT_LEN-1:0]  lat_i,
    input  logic                  grid_en_i,
    output logic [VFD_GRIDS-1:0]  grid_o,
    output logic [VFD_ANODES-1:0] anode_o
);

    // R8: elaboration checks on the routing table
    for (genvar i = 0; i < int'(VFD_OUTS); i++) begin : g_range
        if (OUT_POS[i] >= SHIFT_LEN) begin : g_bad
            $error("output %0d routed to shift position %0d beyond the register", i, OUT_POS[i]);
        end
        for (genvar j = i + 1; j < int'(VFD_OUTS); j++) begin : g_pair
            if (OUT_POS[i] == OUT_POS[j]) begin : g_dup
                $error("outputs %0d and %0d share shift position %0d", i, j, OUT_POS[i]);
            end
        end
    end

    for (genvar g = 0; g < int'(VFD_GRIDS); g++) begin : g_grid
        localparam int unsigned P = OUT_POS[g];
        assign grid_o[g] = lat_i[P] & grid_en_i;
    end

    for (genvar a = 0; a < int'(VFD_ANODES); a++) begin : g_anode
        localparam int unsigned P = OUT_POS[VFD_GRIDS + a];
        assign anode_o[a] = lat_i[P];
    end

endmodule

// File: rtl/vfd_serial_core.sv
module vfd_serial_core
    import vfd_pkg::*;
#(
    parameter int unsigned SHIFT_LEN   = VFD_SHIFT_LEN,
    parameter int unsigned SYNC_STAGES = 2,
    parameter pos_tbl_t    OUT_POS     = VFD_IDENT_POS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk_i,
    input  logic                  ser_dat_i,
    input  logic                  strobe_i,
    input  logic                  grid_en_i,
    output logic [VFD_GRIDS-1:0]  grid_o,
    output logic [VFD_ANODES-1:0] anode_o,
    output logic                  cascade_o
);

    localparam int unsigned IN_W  = 3;
    localparam int unsigned I_CLK = 0;
    localparam int unsigned I_DAT = 1;
    localparam int unsigned I_STB = 2;

    logic [IN_W-1:0]      in_lvl, in_rise, in_fall;
    logic [SHIFT_LEN-1:0] lat;

    vfd_edge_sync #(
        .W      (IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({strobe_i, ser_dat_i, ser_clk_i}),
        .level_o (in_lvl),
        .rise_o  (in_rise),
        .fall_o  (in_fall)
    );

    vfd_shift_latch #(
        .SHIFT_LEN (SHIFT_LEN)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (in_rise[I_CLK]),
        .fall_i  (in_fall[I_CLK]),
        .dat_i   (in_lvl[I_DAT]),
        .stb_i   (in_lvl[I_STB]),
        .lat_o   (lat),
        .casc_o  (cascade_o)
    );

    vfd_out_map #(
        .SHIFT_LEN (SHIFT_LEN),
        .OUT_POS   (OUT_POS)
    ) u_map (
        .lat_i     (lat),
        .grid_en_i (grid_en_i),
        .grid_o    (grid_o),
        .anode_o   (anode_o)
    );

    // R5
    grid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grid_en_i |-> (grid_o == '0));

    // R6
    anode_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(lat) |-> $stable(anode_o));

endmodule

// File: tb/vfd_serial_core_tb.sv
module vfd_serial_core_tb;
    import vfd_pkg::*;

    localparam pos_tbl_t REV_POS = '{
        31, 30, 29, 28, 27, 26, 25, 24,
        23, 22, 21, 20, 19, 18, 17, 16,
        15, 14, 13, 12, 11, 10, 9,  8,
        7,  6,  5,  4,  3,  2,  1,  0
    };

    // {grid enable, word sent lsb first}
    localparam logic [32:0] VECS [6] = '{
        33'h1_FFFF_FFFF,
        33'h1_0000_0001,
        33'h1_8000_0005,
        33'h0_0000_0007,
        33'h1_A5A5_5A5A,
        33'h1_0000_0000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, strobe = 1'b0, grid_en = 1'b0;
    logic [2:0]  grid_a, grid_b;
    logic [28:0] anode_a, anode_b;
    logic        casc_a, casc_b;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_sr  = '0;
    logic [31:0] exp_lat = '0;
    logic        exp_casc = 1'b0;
    logic        exp_stb  = 1'b0;

    always #4 clk = ~clk;

    vfd_serial_core u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .strobe_i(strobe), .grid_en_i(grid_en),
        .grid_o(grid_a), .anode_o(anode_a), .cascade_o(casc_a)
    );

    vfd_serial_core #(.OUT_POS(REV_POS)) u_dut_rev (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .strobe_i(strobe), .grid_en_i(grid_en),
        .grid_o(grid_b), .anode_o(anode_b), .cascade_o(casc_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] want_grid(input pos_tbl_t t, input logic [31:0] l, input logic en);
        logic [2:0] r;
        for (int g = 0; g < 3; g++) r[g] = l[t[g]] & en;
        return r;
    endfunction

    function automatic logic [28:0] want_anode(input pos_tbl_t t, input logic [31:0] l);
        logic [28:0] r;
        for (int a = 0; a < 29; a++) r[a] = l[t[3 + a]];
        return r;
    endfunction

    task automatic check_outputs(input string req);
        check({req, " grid default"}, 32'(grid_a),  32'(want_grid(VFD_IDENT_POS, exp_lat, grid_en)));
        check({req, " anode default"}, 32'(anode_a), 32'(want_anode(VFD_IDENT_POS, exp_lat)));
        check({req, " grid reversed"}, 32'(grid_b),  32'(want_grid(REV_POS, exp_lat, grid_en)));
        check({req, " anode reversed"}, 32'(anode_b), 32'(want_anode(REV_POS, exp_lat)));
    endtask

    task automatic shift_bit(input logic b);
        ser_dat = b;
        tick(3);
        ser_clk = 1'b1;
        tick(6);
        ser_clk = 1'b0;
        tick(6);
        exp_sr   = {b, exp_sr[31:1]};
        exp_casc = exp_sr[0];
        if (exp_stb) exp_lat = exp_sr;
    endtask

    task automatic load_word(input logic [31:0] w);
        for (int i = 0; i < 32; i++) shift_bit(w[i]);
    endtask

    task automatic strobe_pulse();
        strobe = 1'b1;
        tick(6);
        exp_lat = exp_sr;
        strobe = 1'b0;
        tick(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(4);
        // R9: reset state
        check("R9 reset grid", 32'(grid_a), 32'h0);
        check("R9 reset anode", 32'(anode_a), 32'h0);
        check("R9 reset cascade", 32'(casc_a), 32'h0);
        rst_n = 1'b1;
        tick(4);

        // R1 R6 R7 R8: vector table
        for (int v = 0; v < 6; v++) begin
            grid_en = VECS[v][32];
            load_word(VECS[v][31:0]);
            check("R1 cascade after load", 32'(casc_a), 32'(VECS[v][0]));
            strobe_pulse();
            check_outputs("R7 R8 vector");
        end

        // R7: single-bit landmarks with identity table
        grid_en = 1'b1;
        load_word(32'h0000_0008);
        strobe_pulse();
        check("R7 position 4 is anode 1", 32'(anode_a), 32'h1);
        check("R7 no grid for position 4", 32'(grid_a), 32'h0);

        // R4: hold while strobe low
        load_word(32'h8000_0001);
        strobe_pulse();
        for (int i = 0; i < 5; i++) shift_bit(1'b0);
        check("R4 hold anode", 32'(anode_a), 32'h1000_0000);
        check("R4 hold grid", 32'(grid_a), 32'h1);
        check_outputs("R4 hold");

        // R3: transparent while strobe high
        strobe = 1'b1;
        exp_stb = 1'b1;
        tick(6);
        exp_lat = exp_sr;
        check_outputs("R3 transparent entry");
        for (int i = 0; i < 4; i++) begin
            shift_bit(1'b1);
            check_outputs("R3 transparent shift");
        end
        strobe = 1'b0;
        exp_stb = 1'b0;
        tick(6);

        // R5 R6: grid gating leaves anodes untouched
        load_word(32'hFFFF_FFFF);
        strobe_pulse();
        grid_en = 1'b0;
        tick(1);
        check("R5 grids forced low", 32'(grid_a), 32'h0);
        check("R6 anodes ungated", 32'(anode_a), 32'h1FFF_FFFF);
        grid_en = 1'b1;
        tick(1);
        check("R5 grids follow latch", 32'(grid_a), 32'h7);
        check("R6 anodes steady", 32'(anode_a), 32'h1FFF_FFFF);

        // R2: cascade waits for the falling edge
        load_word(32'h0000_0002);
        check("R2 cascade before", 32'(casc_a), 32'h0);
        ser_dat = 1'b0;
        tick(3);
        ser_clk = 1'b1;
        tick(6);
        check("R2 cascade unchanged after rise", 32'(casc_a), 32'h0);
        ser_clk = 1'b0;
        tick(6);
        exp_sr = {1'b0, exp_sr[31:1]};
        exp_casc = exp_sr[0];
        check("R2 cascade after fall", 32'(casc_a), 32'(exp_casc));

        // R9: reset in operation
        load_word(32'hFFFF_FFFF);
        strobe_pulse();
        rst_n = 1'b0;
        tick(3);
        check("R9 mid reset grid", 32'(grid_a), 32'h0);
        check("R9 mid reset anode", 32'(anode_a), 32'h0);
        check("R9 mid reset cascade", 32'(casc_a), 32'h0);
        rst_n = 1'b1;
        exp_sr = '0;
        exp_lat = '0;
        tick(4);
        check_outputs("R9 after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule